// File: doc/BRIEF.md
# Synchronous Serial Receive Buffer with Clock Stall

This block sits behind the bit-level deserializer of a serial channel and holds received frames until software takes them. Every frame arrives as a data word plus one extra bit: the parity bit in 8-bit asynchronous framing, or the top bit in 9-bit framing. The extra bit is stored next to its word through every stage. There are three stages. A landing slot catches each completed frame. A holding slot follows it; in clock-output synchronous mode the holding slot can be switched off. A small FIFO follows the holding slot and can be switched on. The CPU reads from one read port. That port returns the FIFO head when the FIFO is on. When the FIFO is off, it returns the holding slot, or the landing slot when single-buffered.

When the channel drives the serial clock itself, the block drops a clock-enable output whenever all enabled storage is occupied, so no frame can be lost. It can also pulse a receive-enable clear at that moment. In every other mode the holding slot is always active, and a frame that finds no free slot is dropped. The drop is reported in an overrun flag when the FIFO is off, and in a FIFO overrun flag when the FIFO is on. A read of the status port clears both flags.

Two state machines control the block. The slot machine tracks occupancy in four states: FR_EMPTY, FR_FIRST (landing slot only), FR_SECOND (holding slot only) and FR_BOTH. Its transitions are:
- a land moves FR_EMPTY→FR_FIRST or FR_SECOND→FR_BOTH;
- an advance (landing to holding) moves FR_FIRST→FR_SECOND;
- an advance together with a new land keeps the machine in FR_FIRST or in FR_BOTH;
- a holding-slot exit (read or FIFO push) moves FR_SECOND→FR_EMPTY, or FR_BOTH→FR_SECOND through an advance;
- a landing-slot read in single-buffer mode moves FR_FIRST→FR_EMPTY.

The clock machine has the states CK_RUN and CK_HALT. It takes CK_RUN→CK_HALT when a stall condition appears, and CK_HALT→CK_RUN when the condition clears.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset, buf_full, ovr_flag, fifo_ovr_flag, rx_irq and rxe_clr are 0 and sclk_en is 1.
- R2: rd_data/rd_bit9 show the oldest stored frame. The source is the FIFO head when fifo_en=1. When fifo_en=0, the source is the holding slot, or the landing slot when sclk_master=1 and dbuf_en=0. The holding slot is in use whenever sclk_master=0, dbuf_en=1 or fifo_en=1. Frames leave in arrival order.
- R3: A rd_strobe cycle removes the shown frame at that clock edge. When storage then holds nothing readable, buf_full reads 0 in the next cycle.
- R4: A frame lands in the landing slot at the edge where frame_done=1. It advances into a free (or emptying) holding slot at the next edge. It enters the FIFO one edge later if the FIFO is below capacity. rx_irq is high for exactly the one cycle after the edge where a frame becomes readable.
- R5: With sclk_master=1, dbuf_en=0 and fifo_en=0, sclk_en goes 0 in the cycle after each frame lands. It returns to 1 after the read of that frame.
- R6: With sclk_master=1, dbuf_en=1 and fifo_en=0, sclk_en goes 0 when both slots hold frames. Reading the holding slot moves the landing frame into it at the same edge, pulses rx_irq and returns sclk_en to 1.
- R7: With sclk_master=1 and fifo_en=1, the FIFO accepts at most L entries, where L is stall_lvl (1..4, with 0 or values above 4 meaning 4). sclk_en goes 0 once the FIFO holds L entries and both slots are full, that is after exactly L+2 frames.
- R8: When auto_stop=1, rxe_clr is high for one cycle, in the first cycle sclk_en is 0. When auto_stop=0, rxe_clr stays 0.
- R9: With sclk_master=0 and fifo_en=0, a frame arriving while both slots are full is dropped and ovr_flag is set. The holding slot's word and extra bit stay unchanged.
- R10: With sclk_master=0 and fifo_en=1, a frame arriving while the FIFO and both slots are full is dropped and fifo_ovr_flag is set; ovr_flag stays 0. All stored frames still read out in order.
- R11: A stat_rd cycle clears ovr_flag and fifo_ovr_flag at that edge. ovr_flag never sets while sclk_master=1.
- R12: The extra bit (frame_bit9) is returned on rd_bit9 together with its own word in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe: a frame is complete |
| frame_data | input | DW | Received frame word |
| frame_bit9 | input | 1 | Parity or top bit of the frame |
| sclk_master | input | 1 | 1: clock-output synchronous mode |
| dbuf_en | input | 1 | Holding slot enable (clock-output mode) |
| fifo_en | input | 1 | Receive FIFO enable |
| stall_lvl | input | CW | FIFO fill level for the stall in clock-output mode |
| auto_stop | input | 1 | Clear receive-enable when the clock stalls |
| rd_strobe | input | 1 | CPU read of the data port |
| stat_rd | input | 1 | CPU read of the status port |
| rd_data | output | DW | Read data word |
| rd_bit9 | output | 1 | Extra bit of the read word |
| buf_full | output | 1 | A readable frame is present |
| ovr_flag | output | 1 | Overrun, FIFO off |
| fifo_ovr_flag | output | 1 | Overrun, FIFO on |
| rx_irq | output | 1 | One-cycle receive interrupt |
| sclk_en | output | 1 | Serial clock enable |
| rxe_clr | output | 1 | One-cycle receive-enable clear |

## Verification
Inputs are driven on falling edges and outputs are sampled on falling edges, so every sample sees the state left by the last rising edge.

- **Single-buffer and holding-slot results.** A frame strobed before edge t is in the landing slot at t. In single-buffer mode, sclk_en, rxe_clr, rx_irq and buf_full are therefore checked at the first falling edge after t. With the holding slot in use, rx_irq and read data are checked one falling edge later.
- **FIFO results.** With the FIFO in use, frames are sent two cycles apart. Reads are spaced three cycles apart so that each refill (push at the next edge) is done before the next read.
- **Flags and reads.** Overrun flags and the effects of a read are checked at the falling edge right after the edge that took the strobe.
- **Stall level sweep.** Across all eight stall_lvl codes, the number of frames accepted before sclk_en drops is compared against L+2.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [1:0] {
        FR_EMPTY,
        FR_FIRST,
        FR_SECOND,
        FR_BOTH
    } fr_state_t;

    typedef enum logic {
        CK_RUN,
        CK_HALT
    } ck_state_t;

endpackage

// File: rtl/srb_fifo.sv
module srb_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          room
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_comb begin
        dout = mem[rp];
        room = (count < cap);
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));  // R10

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));  // R3

endmodule

// File: rtl/srb_front.sv
module srb_front
    import srb_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_done,
    input  logic [W-1:0] frame_word,
    input  logic         dbuf_eff,
    input  logic         fifo_en,
    input  logic         fifo_room,
    input  logic         rd_b1,
    input  logic         rd_b2,
    output logic         b1_v,
    output logic         b2_v,
    output logic [W-1:0] b1_word,
    output logic [W-1:0] b2_word,
    output logic         push_fifo,
    output logic         b1_move,
    output logic         land,
    output logic         lost
);

    fr_state_t st;
    fr_state_t st_nx;
    logic      pop_b1;
    logic      pop_b2;
    logic      b2_leave;
    logic      n1;
    logic      n2;

    always_comb begin
        unique case (st)
            FR_EMPTY:  begin b1_v = 1'b0; b2_v = 1'b0; end
            FR_FIRST:  begin b1_v = 1'b1; b2_v = 1'b0; end
            FR_SECOND: begin b1_v = 1'b0; b2_v = 1'b1; end
            FR_BOTH:   begin b1_v = 1'b1; b2_v = 1'b1; end
            default:   begin b1_v = 1'b0; b2_v = 1'b0; end
        endcase
    end

    always_comb begin
        pop_b1    = rd_b1 & b1_v & ~dbuf_eff;
        pop_b2    = rd_b2 & b2_v;
        push_fifo = fifo_en & dbuf_eff & b2_v & fifo_room;
        b2_leave  = push_fifo | pop_b2;
        b1_move   = dbuf_eff & b1_v & (~b2_v | b2_leave);
        land      = frame_done & (~b1_v | b1_move | pop_b1);
        lost      = frame_done & ~land;
        n1        = land | (b1_v & ~b1_move & ~pop_b1);
        n2        = b1_move | (b2_v & ~b2_leave);
        unique case ({n1, n2})
            2'b00:   st_nx = FR_EMPTY;
            2'b10:   st_nx = FR_FIRST;
            2'b01:   st_nx = FR_SECOND;
            2'b11:   st_nx = FR_BOTH;
            default: st_nx = FR_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FR_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b1_word <= '0;
            b2_word <= '0;
        end else begin
            if (land)    b1_word <= frame_word;
            if (b1_move) b2_word <= b1_word;
        end
    end

    AST_LOST_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> ($stable(b1_word) && $stable(b2_word)));  // R9

    AST_LOST_ONLY_WHEN_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (st == FR_BOTH || (st == FR_FIRST && !dbuf_eff)));  // R9

endmodule

// File: rtl/srb_clk_fsm.sv
module srb_clk_fsm
    import srb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic dbuf_eff,
    input  logic fifo_en,
    input  logic fifo_room,
    input  logic b1_v,
    input  logic b2_v,
    input  logic auto_stop,
    output logic sclk_en,
    output logic rxe_clr
);

    ck_state_t st;
    ck_state_t st_nx;
    logic      stall_req;

    always_comb begin
        stall_req = master & b1_v &
                    (dbuf_eff ? (b2_v & (~fifo_en | ~fifo_room)) : 1'b1);
        unique case (st)
            CK_RUN:  st_nx = stall_req ? CK_HALT : CK_RUN;
            CK_HALT: st_nx = stall_req ? CK_HALT : CK_RUN;
            default: st_nx = CK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CK_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        sclk_en = ~stall_req;
        rxe_clr = 1'b0;
        unique case (st)
            CK_RUN:  rxe_clr = stall_req & auto_stop;
            CK_HALT: rxe_clr = 1'b0;
            default: rxe_clr = 1'b0;
        endcase
    end

    AST_RXE_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rxe_clr |=> !rxe_clr);  // R8

    AST_RXE_CLR_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        rxe_clr |-> (!sclk_en && master));  // R8

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import srb_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int W    = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic [DW-1:0] frame_data,
    input  logic          frame_bit9,
    input  logic          sclk_master,
    input  logic          dbuf_en,
    input  logic          fifo_en,
    input  logic [CW-1:0] stall_lvl,
    input  logic          auto_stop,
    input  logic          rd_strobe,
    input  logic          stat_rd,
    output logic [DW-1:0] rd_data,
    output logic          rd_bit9,
    output logic          buf_full,
    output logic          ovr_flag,
    output logic          fifo_ovr_flag,
    output logic          rx_irq,
    output logic          sclk_en,
    output logic          rxe_clr
);

    logic          dbuf_eff;
    logic [CW-1:0] cap;
    logic [CW-1:0] lvl_eff;
    logic          b1_v;
    logic          b2_v;
    logic [W-1:0]  b1_word;
    logic [W-1:0]  b2_word;
    logic [W-1:0]  fifo_dout;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_room;
    logic          push_fifo;
    logic          b1_move;
    logic          land;
    logic          lost;
    logic          rd_b1;
    logic          rd_b2;
    logic          rd_fifo;
    logic          irq_nx;
    logic [W-1:0]  shown;

    always_comb begin
        dbuf_eff = ~sclk_master | dbuf_en | fifo_en;
        if (stall_lvl == '0 || stall_lvl > CW'(DEPTH)) lvl_eff = CW'(DEPTH);
        else                                          lvl_eff = stall_lvl;
        cap     = sclk_master ? lvl_eff : CW'(DEPTH);
        rd_b1   = rd_strobe & ~fifo_en & ~dbuf_eff;
        rd_b2   = rd_strobe & ~fifo_en & dbuf_eff;
        rd_fifo = rd_strobe & fifo_en & (fifo_cnt != '0);
    end

    srb_front #(.W(W)) i_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word ({frame_bit9, frame_data}),
        .dbuf_eff   (dbuf_eff),
        .fifo_en    (fifo_en),
        .fifo_room  (fifo_room),
        .rd_b1      (rd_b1),
        .rd_b2      (rd_b2),
        .b1_v       (b1_v),
        .b2_v       (b2_v),
        .b1_word    (b1_word),
        .b2_word    (b2_word),
        .push_fifo  (push_fifo),
        .b1_move    (b1_move),
        .land       (land),
        .lost       (lost)
    );

    srb_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_fifo),
        .pop   (rd_fifo),
        .din   (b2_word),
        .cap   (cap),
        .dout  (fifo_dout),
        .count (fifo_cnt),
        .room  (fifo_room)
    );

    srb_clk_fsm i_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .master    (sclk_master),
        .dbuf_eff  (dbuf_eff),
        .fifo_en   (fifo_en),
        .fifo_room (fifo_room),
        .b1_v      (b1_v),
        .b2_v      (b2_v),
        .auto_stop (auto_stop),
        .sclk_en   (sclk_en),
        .rxe_clr   (rxe_clr)
    );

    always_comb begin
        if (fifo_en) begin
            shown    = fifo_dout;
            buf_full = (fifo_cnt != '0);
            irq_nx   = push_fifo;
        end else if (dbuf_eff) begin
            shown    = b2_word;
            buf_full = b2_v;
            irq_nx   = b1_move;
        end else begin
            shown    = b1_word;
            buf_full = b1_v;
            irq_nx   = land;
        end
        rd_data = shown[DW-1:0];
        rd_bit9 = shown[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_irq        <= 1'b0;
            ovr_flag      <= 1'b0;
            fifo_ovr_flag <= 1'b0;
        end else begin
            rx_irq <= irq_nx;
            if (lost && !sclk_master && !fifo_en) ovr_flag <= 1'b1;
            else if (stat_rd)                     ovr_flag <= 1'b0;
            if (lost && !sclk_master && fifo_en)  fifo_ovr_flag <= 1'b1;
            else if (stat_rd)                     fifo_ovr_flag <= 1'b0;
        end
    end

    AST_NO_OVR_IN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_master && !ovr_flag) |=> !ovr_flag);  // R11

    AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);  // R4

    AST_FIFO_OVR_NOT_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !ovr_flag) |=> !ovr_flag);  // R10

endmodule

// File: tb/test_serial_rx_buffer.sv
`timescale 1ns/1ps
module test_serial_rx_buffer;

    localparam int DW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_done = 1'b0;
    logic [DW-1:0] frame_data = '0;
    logic          frame_bit9 = 1'b0;
    logic          sclk_master = 1'b0;
    logic          dbuf_en = 1'b0;
    logic          fifo_en = 1'b0;
    logic [CW-1:0] stall_lvl = '0;
    logic          auto_stop = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          stat_rd = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_bit9;
    logic          buf_full;
    logic          ovr_flag;
    logic          fifo_ovr_flag;
    logic          rx_irq;
    logic          sclk_en;
    logic          rxe_clr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [DW:0] got;

    always #5 clk = ~clk;

    serial_rx_buffer #(.DW(DW), .DEPTH(4)) i_serial_rx_buffer (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
        .frame_bit9(frame_bit9), .sclk_master(sclk_master), .dbuf_en(dbuf_en),
        .fifo_en(fifo_en), .stall_lvl(stall_lvl), .auto_stop(auto_stop),
        .rd_strobe(rd_strobe), .stat_rd(stat_rd), .rd_data(rd_data), .rd_bit9(rd_bit9),
        .buf_full(buf_full), .ovr_flag(ovr_flag), .fifo_ovr_flag(fifo_ovr_flag),
        .rx_irq(rx_irq), .sclk_en(sclk_en), .rxe_clr(rxe_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [DW-1:0] d, input logic b);
        @(negedge clk);
        frame_done = 1'b1; frame_data = d; frame_bit9 = b;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic do_read(output logic [DW:0] w);
        @(negedge clk);
        rd_strobe = 1'b1;
        w = {rd_bit9, rd_data};
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic status_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic [DW:0] pat(input int i);
        logic [DW-1:0] d;
        d = DW'(i * 37 + 11);
        return {d[0] ^ d[3], d};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 buf_full", buf_full, 0);
        chk("R1 sclk_en", sclk_en, 1);
        chk("R1 flags", {ovr_flag, fifo_ovr_flag, rx_irq, rxe_clr}, 0);

        // Asynchronous, FIFO off: holding slot active
        send(8'h5A, 1'b1);
        chk("R4 not readable while landing", buf_full, 0);
        chk("R4 no irq yet", rx_irq, 0);
        @(negedge clk);
        chk("R4 irq after advance", rx_irq, 1);
        chk("R2 shown word", {rd_bit9, rd_data}, 9'h15A);
        @(negedge clk);
        chk("R4 irq one cycle", rx_irq, 0);
        send(8'hA5, 1'b0);
        chk("R9 no overrun with free landing slot", ovr_flag, 0);
        send(8'h3C, 1'b1);
        chk("R9 overrun set", ovr_flag, 1);
        chk("R9 holding word kept", {rd_bit9, rd_data}, 9'h15A);
        chk("R10 fifo overrun untouched", fifo_ovr_flag, 0);
        do_read(got);
        chk("R2 first read", got, 9'h15A);
        chk("R6 advance on read irq", rx_irq, 1);
        chk("R12 second frame bit", {rd_bit9, rd_data}, 9'h0A5);
        do_read(got);
        chk("R9 dropped frame absent", got, 9'h0A5);
        chk("R3 empty after read", buf_full, 0);
        status_read();
        chk("R11 status read clears", ovr_flag, 0);

        // R2 R12 sweep of words through the holding slot
        for (int i = 0; i < 16; i++) begin
            send(pat(i)[DW-1:0], pat(i)[DW]);
            idle(1);
            chk("R12 sweep word", {rd_bit9, rd_data}, pat(i));
            chk("R3 full before read", buf_full, 1);
            do_read(got);
            chk("R3 empty after sweep read", buf_full, 0);
        end
        chk("R9 no overrun in sweep", ovr_flag, 0);

        // Asynchronous, FIFO on
        fifo_en = 1'b1;
        do_reset();
        for (int i = 0; i < 6; i++) send(pat(i + 20)[DW-1:0], pat(i + 20)[DW]);
        idle(3);
        chk("R10 stored frames", buf_full, 1);
        chk("R10 no fifo overrun yet", fifo_ovr_flag, 0);
        send(8'hEE, 1'b1);
        chk("R10 fifo overrun set", fifo_ovr_flag, 1);
        chk("R10 main overrun clear", ovr_flag, 0);
        for (int i = 0; i < 6; i++) begin
            do_read(got);
            chk("R10 fifo order", got, pat(i + 20));
            idle(2);
        end
        chk("R3 fifo drained", buf_full, 0);
        status_read();
        chk("R11 fifo overrun cleared", fifo_ovr_flag, 0);

        // Clock-output, single buffer
        fifo_en = 1'b0; sclk_master = 1'b1; dbuf_en = 1'b0; auto_stop = 1'b1;
        do_reset();
        send(8'hC3, 1'b1);
        chk("R5 stall after frame", sclk_en, 0);
        chk("R5 readable in landing slot", buf_full, 1);
        chk("R4 single irq", rx_irq, 1);
        chk("R8 rxe clear pulse", rxe_clr, 1);
        chk("R2 landing word", {rd_bit9, rd_data}, 9'h1C3);
        @(negedge clk);
        chk("R8 rxe clear one cycle", rxe_clr, 0);
        chk("R5 still stalled", sclk_en, 0);
        do_read(got);
        chk("R5 read word", got, 9'h1C3);
        chk("R5 resume after read", sclk_en, 1);
        chk("R11 no overrun in master", ovr_flag, 0);

        // Clock-output, double buffer
        dbuf_en = 1'b1; auto_stop = 1'b0;
        do_reset();
        send(8'h11, 1'b0);
        idle(1);
        chk("R6 one frame no stall", sclk_en, 1);
        send(8'h22, 1'b1);
        chk("R6 stall when both full", sclk_en, 0);
        chk("R8 no clear without auto stop", rxe_clr, 0);
        do_read(got);
        chk("R6 read holding word", got, 9'h011);
        chk("R6 resume", sclk_en, 1);
        chk("R6 irq on advance", rx_irq, 1);
        chk("R12 moved bit", {rd_bit9, rd_data}, 9'h122);
        do_read(got);
        chk("R3 double empty", buf_full, 0);

        // Clock-output with FIFO: sweep every level code
        dbuf_en = 1'b0; fifo_en = 1'b1;
        for (int lv = 0; lv < 8; lv++) begin
            int exp_cap;
            int n;
            exp_cap = (lv == 0 || lv > 4) ? 4 : lv;
            stall_lvl = CW'(lv);
            auto_stop = lv[0];
            do_reset();
            n = 0;
            while (sclk_en && n < 12) begin
                send(pat(n + 40 + lv)[DW-1:0], pat(n + 40 + lv)[DW]);
                n++;
                if (!sclk_en) chk("R8 level rxe clear", rxe_clr, lv[0]);
            end
            chk("R7 frames before stall", n, exp_cap + 2);
            for (int k = 0; k < n; k++) begin
                do_read(got);
                chk("R7 level order", got, pat(k + 40 + lv));
                if (k == 0) chk("R7 resume after read", sclk_en, 1);
                idle(2);
            end
            chk("R3 level drained", buf_full, 0);
            chk("R11 master no overrun", {ovr_flag, fifo_ovr_flag}, 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule